// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two 32-bit operands and adds the product to, or subtracts it from, one of four 48-bit accumulators. Each operation chooses one of three arithmetic modes: signed integer, unsigned integer or fractional. A mode-specific product check runs first. In saturate mode, a product that overflows is replaced by a large constant, and that constant is certain to push the following accumulate into overflow. After the product check, the product can be shifted one bit left or right before it reaches the adder.

After each accumulate, a saturation stage tests the new sum against the accumulator range. When the saturate control is set, it clamps the value to a mode-specific limit. The operation overflow flag reports the most recent multiply-accumulate. Each accumulator also has a sticky overflow bit, and only a clear command for that accumulator resets it. Operand fetch and instruction decode take place outside the block. The caller presents one operation per cycle on a valid strobe, and operations may be issued back to back.

Top module: `mac_unit`

## Requirements
- R1: Reset sets all four accumulators to zero and clears ovfFlag, every accOvf bit and doneValid.
- R2: An operation accepted with opValid at clock edge N updates its accumulator and flags at edge N+2, where doneValid is high for exactly one cycle. Back-to-back operations retire in issue order, and each one sees the result of the operation before it.
- R3: Signed integer mode (opMode 0, and the unused code 3) forms the signed 64-bit product. The product overflows when it does not fit 40 signed bits. With saturate off, an overflowing product is cut to its low 40 bits and sign-extended.
- R4: With saturate on, an overflowing signed product becomes +2^50 when it is positive and the bitwise complement of 2^50 when it is negative.
- R5: Unsigned mode (opMode 1) forms the unsigned product. Any set bit at position 40 or higher is an overflow. The product then becomes 2^50 with saturate on, and its low 40 bits with saturate off.
- R6: Fractional mode (opMode 2) shifts the signed product right arithmetically by 24 bits. It never reports a product overflow. With roundEn set, a dropped part above 0x800000 rounds up, and a dropped part of exactly 0x800000 rounds to the nearest even value. With roundEn clear, the dropped bits are simply discarded.
- R7: opShift 1 doubles the checked product and opShift 2 halves it (logical shift in unsigned mode, arithmetic otherwise). The shift is applied after the overflow substitution and before the add or subtract. Codes 0 and 3 leave the product unshifted.
- R8: opSub 0 adds the product to the selected accumulator and opSub 1 subtracts the product from it.
- R9: In signed and fractional modes the accumulator is sign-extended, and a sum that does not fit 48 signed bits is an overflow. ovfFlag becomes product overflow OR sum overflow, and when it is set, accOvf[opIdx] is set as well.
- R10: When ovfFlag is set and saturate is on, a signed integer result clamps to 0x7FFFFFFF or -2^31, and a fractional result clamps to 2^47-1 or -2^47, following the sign of the exact sum. With saturate off, the sum wraps to 48 bits.
- R11: In unsigned mode the accumulator is zero-extended, and any nonzero sum bit at 48 or above is an overflow. When saturating after an overflow, the result is 0 if the sum exceeds 2^53 and 2^48-1 otherwise. With saturate off, the sum is truncated to 48 bits.
- R12: A clear command (opClear with opValid) zeroes accumulator opIdx and its accOvf bit, leaves ovfFlag unchanged and pulses doneValid at the same time a multiply-accumulate would.
- R13: An accOvf bit stays set through later operations that do not overflow. An operation changes only its own accumulator and accOvf bit. No output changes in a cycle without doneValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation strobe, one operation per cycle |
| opClear | input | 1 | With opValid: clear accumulator opIdx instead of a multiply-accumulate |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opMode | input | 2 | 0 signed, 1 unsigned, 2 fractional, 3 signed |
| opShift | input | 2 | 0 none, 1 left by one, 2 right by one, 3 none |
| opSub | input | 1 | 1 subtracts the product, 0 adds it |
| opIdx | input | 2 | Accumulator index |
| satMode | input | 1 | Overflow saturation enable, sampled with the operation |
| roundEn | input | 1 | Fractional rounding enable, sampled with the operation |
| doneValid | output | 1 | One-cycle pulse when an operation has been written back |
| ovfFlag | output | 1 | Overflow of the most recent multiply-accumulate |
| accOvf | output | 4 | Sticky overflow bit per accumulator |
| accFlat | output | 192 | All accumulators, accumulator k at bits [48k+47:48k] |

## Verification
The bench targets the places where a product check can slip. These are products just past 40 bits in signed and unsigned mode, both clamp directions, and fractional remainders of exactly half with an even and with an odd quotient. A unit with a wrong product limit or a wrong forced constant leaves an accumulator unclamped, and the scoreboard sees a sum that has wrapped. A unit that rounds half up, or rounds in the wrong direction for negative values, is off by one in the fractional accumulator. The bench runs unsigned subtracts that underflow, with saturate on and off: a unit that compares against the wrong limit clamps to the maximum where zero is expected. Long accumulation runs push sums across the 48-bit signed boundary in both directions. A sticky bit lost on a later clean operation, or a write that leaks into a neighbouring accumulator, shows up in the full four-accumulator comparison made on every result.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    MODE_SINT = 2'b00,
    MODE_UINT = 2'b01,
    MODE_FRAC = 2'b10,
    MODE_RSVD = 2'b11
  } macMode_e;

  typedef enum logic [1:0] {
    SHIFT_NONE  = 2'b00,
    SHIFT_LEFT  = 2'b01,
    SHIFT_RIGHT = 2'b10,
    SHIFT_RSVD  = 2'b11
  } prodShift_e;

  // Strobes from the control sequencer to the datapath
  typedef struct packed {
    logic captureOp;
    logic commitMac;
    logic commitClr;
  } macStrobes_t;

endpackage

// File: rtl/mac_product.sv
module mac_product
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 48
) (
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  macMode_e            mode,
  input  prodShift_e          shift,
  input  logic                satMode,
  input  logic                roundEn,
  output logic [2*DATA_W-1:0] prodVal,
  output logic                prodOvf
);
  localparam int PW        = 2 * DATA_W;
  localparam int PROD_W    = ACC_W - 8;
  localparam int FORCE_BIT = ACC_W + 2;
  localparam int FRAC_SH   = ACC_W / 2;
  localparam int EXT_W     = PW - PROD_W;
  localparam logic [PW-1:0]      FORCE_POS = PW'(1) << FORCE_BIT;
  localparam logic [FRAC_SH-1:0] HALF      = FRAC_SH'(1) << (FRAC_SH - 1);

  logic signed [PW-1:0] sProd;
  logic        [PW-1:0] uProd;
  logic signed [PW-1:0] fracQ;
  logic [FRAC_SH-1:0]   fracRem;
  logic                 fracUp;
  logic [EXT_W:0]       sUpper;
  logic                 sFits;
  logic signed [PW-1:0] checked;

  always_comb begin
    sProd   = $signed({{DATA_W{opA[DATA_W-1]}}, opA}) * $signed({{DATA_W{opB[DATA_W-1]}}, opB});
    uProd   = {{DATA_W{1'b0}}, opA} * {{DATA_W{1'b0}}, opB};
    fracRem = sProd[FRAC_SH-1:0];
    fracQ   = sProd >>> FRAC_SH;
    fracUp  = roundEn && ((fracRem > HALF) || ((fracRem == HALF) && fracQ[0]));
    sUpper  = sProd[PW-1:PROD_W-1];
    sFits   = (&sUpper) | ~(|sUpper);
  end

  // Mode-dependent overflow handling
  always_comb begin
    prodOvf = 1'b0;
    checked = sProd;
    unique case (mode)
      MODE_UINT: begin
        if (|uProd[PW-1:PROD_W]) begin
          prodOvf = 1'b1;
          checked = satMode ? FORCE_POS : {{EXT_W{1'b0}}, uProd[PROD_W-1:0]};
        end else begin
          checked = uProd;
        end
      end
      MODE_FRAC: begin
        checked = fracUp ? fracQ + PW'(1) : fracQ;
      end
      default: begin
        if (!sFits) begin
          prodOvf = 1'b1;
          if (satMode) checked = sProd[PW-1] ? ~FORCE_POS : FORCE_POS;
          else         checked = {{EXT_W{sProd[PROD_W-1]}}, sProd[PROD_W-1:0]};
        end
      end
    endcase
  end

  // Optional one-bit scaling after the overflow handling
  always_comb begin
    unique case (shift)
      SHIFT_LEFT:  prodVal = checked << 1;
      SHIFT_RIGHT: prodVal = (mode == MODE_UINT) ? ($unsigned(checked) >> 1)
                                                 : $unsigned(checked >>> 1);
      default:     prodVal = checked;
    endcase
  end

endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 48
) (
  input  logic [ACC_W-1:0]    accIn,
  input  logic [2*DATA_W-1:0] prodVal,
  input  logic                prodOvf,
  input  macMode_e            mode,
  input  logic                subOp,
  input  logic                satMode,
  output logic [ACC_W-1:0]    accNext,
  output logic                ovfOut
);
  localparam int PW      = 2 * DATA_W;
  localparam int EXT_W   = PW - ACC_W;
  localparam int UNS_BIT = ACC_W + 5;
  localparam logic [PW-1:0]    UNS_LIM  = PW'(1) << UNS_BIT;
  localparam logic [ACC_W-1:0] INT_MAX  = ACC_W'({(DATA_W-1){1'b1}});
  localparam logic [ACC_W-1:0] INT_MIN  = ~INT_MAX;
  localparam logic [ACC_W-1:0] FRAC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] FRAC_MIN = ~FRAC_MAX;

  logic [PW-1:0]  extAcc;
  logic [PW-1:0]  sum;
  logic [EXT_W:0] sUpper;
  logic           sumOvf;
  logic           negSum;

  always_comb begin
    if (mode == MODE_UINT) extAcc = {{EXT_W{1'b0}}, accIn};
    else                   extAcc = {{EXT_W{accIn[ACC_W-1]}}, accIn};
    sum    = subOp ? (extAcc - prodVal) : (extAcc + prodVal);
    sUpper = sum[PW-1:ACC_W-1];
    negSum = sum[PW-1];
  end

  always_comb begin
    accNext = sum[ACC_W-1:0];
    if (mode == MODE_UINT) begin
      sumOvf = |sum[PW-1:ACC_W];
      ovfOut = sumOvf | prodOvf;
      if (ovfOut && satMode) accNext = (sum > UNS_LIM) ? '0 : '1;
    end else begin
      sumOvf = ~((&sUpper) | ~(|sUpper));
      ovfOut = sumOvf | prodOvf;
      if (ovfOut && satMode) begin
        if (mode == MODE_FRAC) accNext = negSum ? FRAC_MIN : FRAC_MAX;
        else                   accNext = negSum ? INT_MIN : INT_MAX;
      end
    end
  end

endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic        opClear,
  output macStrobes_t strobes,
  output logic        doneValid
);
  logic stageValid;
  logic stageClr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      stageClr   <= 1'b0;
      doneValid  <= 1'b0;
    end else begin
      stageValid <= opValid;
      stageClr   <= opValid & opClear;
      doneValid  <= stageValid;
    end
  end

  always_comb begin
    strobes.captureOp = opValid;
    strobes.commitMac = stageValid & ~stageClr;
    strobes.commitClr = stageValid & stageClr;
  end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ACC_W   = 48,
  parameter int NUM_ACC = 4,
  localparam int IDX_W  = $clog2(NUM_ACC)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  macStrobes_t              strobes,
  input  logic [DATA_W-1:0]        opA,
  input  logic [DATA_W-1:0]        opB,
  input  macMode_e                 mode,
  input  prodShift_e               shift,
  input  logic                     subOp,
  input  logic [IDX_W-1:0]         idx,
  input  logic                     satMode,
  input  logic                     roundEn,
  output logic                     ovfFlag,
  output logic [NUM_ACC-1:0]       accOvf,
  output logic [NUM_ACC*ACC_W-1:0] accFlat
);
  localparam int PW = 2 * DATA_W;

  logic [PW-1:0]    prodComb;
  logic             prodOvfComb;
  logic [PW-1:0]    prodReg;
  logic             prodOvfReg;
  macMode_e         modeReg;
  logic             subReg;
  logic             satReg;
  logic [IDX_W-1:0] idxReg;

  logic [ACC_W-1:0] accReg [NUM_ACC];
  logic             ovfArr [NUM_ACC];
  logic [ACC_W-1:0] accSel;
  logic [ACC_W-1:0] accNext;
  logic             ovfNext;

  mac_product #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_product (
    .opA     (opA),
    .opB     (opB),
    .mode    (mode),
    .shift   (shift),
    .satMode (satMode),
    .roundEn (roundEn),
    .prodVal (prodComb),
    .prodOvf (prodOvfComb)
  );

  // Product stage register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodReg    <= '0;
      prodOvfReg <= 1'b0;
      modeReg    <= MODE_SINT;
      subReg     <= 1'b0;
      satReg     <= 1'b0;
      idxReg     <= '0;
    end else if (strobes.captureOp) begin
      prodReg    <= prodComb;
      prodOvfReg <= prodOvfComb;
      modeReg    <= mode;
      subReg     <= subOp;
      satReg     <= satMode;
      idxReg     <= idx;
    end
  end

  assign accSel = accReg[idxReg];

  mac_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_accum (
    .accIn   (accSel),
    .prodVal (prodReg),
    .prodOvf (prodOvfReg),
    .mode    (modeReg),
    .subOp   (subReg),
    .satMode (satReg),
    .accNext (accNext),
    .ovfOut  (ovfNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN)                  ovfFlag <= 1'b0;
    else if (strobes.commitMac) ovfFlag <= ovfNext;
  end

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    always_ff @(posedge clk) begin
      if (!rstN) begin
        accReg[g] <= '0;
        ovfArr[g] <= 1'b0;
      end else if (idxReg == IDX_W'(g)) begin
        if (strobes.commitClr) begin
          accReg[g] <= '0;
          ovfArr[g] <= 1'b0;
        end else if (strobes.commitMac) begin
          accReg[g] <= accNext;
          if (ovfNext) ovfArr[g] <= 1'b1;
        end
      end
    end
    assign accFlat[g*ACC_W +: ACC_W] = accReg[g];
    assign accOvf[g] = ovfArr[g];
  end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ACC_W   = 48,
  parameter int NUM_ACC = 4,
  localparam int IDX_W  = $clog2(NUM_ACC)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     opValid,
  input  logic                     opClear,
  input  logic [DATA_W-1:0]        opA,
  input  logic [DATA_W-1:0]        opB,
  input  logic [1:0]               opMode,
  input  logic [1:0]               opShift,
  input  logic                     opSub,
  input  logic [IDX_W-1:0]         opIdx,
  input  logic                     satMode,
  input  logic                     roundEn,
  output logic                     doneValid,
  output logic                     ovfFlag,
  output logic [NUM_ACC-1:0]       accOvf,
  output logic [NUM_ACC*ACC_W-1:0] accFlat
);
  macStrobes_t strobes;

  mac_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .opClear   (opClear),
    .strobes   (strobes),
    .doneValid (doneValid)
  );

  mac_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W), .NUM_ACC(NUM_ACC)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .mode    (macMode_e'(opMode)),
    .shift   (prodShift_e'(opShift)),
    .subOp   (opSub),
    .idx     (opIdx),
    .satMode (satMode),
    .roundEn (roundEn),
    .ovfFlag (ovfFlag),
    .accOvf  (accOvf),
    .accFlat (accFlat)
  );

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int ACC_W   = 48,
  parameter int NUM_ACC = 4,
  localparam int IDX_W  = $clog2(NUM_ACC)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     opValid,
  input logic                     opClear,
  input logic [1:0]               opMode,
  input logic [IDX_W-1:0]         opIdx,
  input logic                     satMode,
  input logic                     doneValid,
  input logic                     ovfFlag,
  input logic [NUM_ACC-1:0]       accOvf,
  input logic [NUM_ACC*ACC_W-1:0] accFlat
);
  localparam logic [ACC_W-1:0] INT_MAX  = ACC_W'({(DATA_W-1){1'b1}});
  localparam logic [ACC_W-1:0] FRAC_MAX = {1'b0, {(ACC_W-1){1'b1}}};

  // Two-stage shadow of the issued operation, aligned with doneValid
  logic             p1Valid, p2Valid, p1Clr, p2Clr, p1Sat, p2Sat;
  logic [1:0]       p1Mode, p2Mode;
  logic [IDX_W-1:0] p1Idx, p2Idx;
  logic [ACC_W-1:0] selAcc;
  logic             selOvf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      p1Valid <= 1'b0; p2Valid <= 1'b0; p1Clr <= 1'b0; p2Clr <= 1'b0;
      p1Sat <= 1'b0; p2Sat <= 1'b0; p1Mode <= '0; p2Mode <= '0;
      p1Idx <= '0; p2Idx <= '0;
    end else begin
      p1Valid <= opValid; p1Clr <= opClear; p1Sat <= satMode;
      p1Mode <= opMode; p1Idx <= opIdx;
      p2Valid <= p1Valid; p2Clr <= p1Clr; p2Sat <= p1Sat;
      p2Mode <= p1Mode; p2Idx <= p1Idx;
    end
  end

  assign selAcc = accFlat[p2Idx*ACC_W +: ACC_W];
  assign selOvf = accOvf[p2Idx];

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> ##2 doneValid);

  assert_done_origin_R2: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> p2Valid);

  assert_hold_quiet_R13: assert property (@(posedge clk) disable iff (!rstN)
    !doneValid |-> ($stable(accFlat) && $stable(accOvf) && $stable(ovfFlag)));

  assert_sticky_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !p2Clr && ovfFlag) |-> selOvf);

  assert_clear_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && p2Clr) |-> (selAcc == '0 && !selOvf));

  assert_int_clamp_R10: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !p2Clr && ovfFlag && p2Sat && (p2Mode == 2'd0 || p2Mode == 2'd3))
      |-> (selAcc == INT_MAX || selAcc == ~INT_MAX));

  assert_frac_clamp_R10: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !p2Clr && ovfFlag && p2Sat && p2Mode == 2'd2)
      |-> (selAcc == FRAC_MAX || selAcc == ~FRAC_MAX));

  assert_uns_clamp_R11: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !p2Clr && ovfFlag && p2Sat && p2Mode == 2'd1)
      |-> (selAcc == '0 || selAcc == '1));

endmodule

bind mac_unit mac_unit_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W), .NUM_ACC(NUM_ACC)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opClear   (opClear),
  .opMode    (opMode),
  .opIdx     (opIdx),
  .satMode   (satMode),
  .doneValid (doneValid),
  .ovfFlag   (ovfFlag),
  .accOvf    (accOvf),
  .accFlat   (accFlat)
);

// File: tb/mac_unit_bench.sv
`timescale 1ns/1ps
module mac_unit_bench;
  localparam int NA = 4;
  localparam int AW = 48;

  logic         clk = 1'b0;
  logic         rstN;
  logic         opValid, opClear, opSub, satMode, roundEn;
  logic [31:0]  opA, opB;
  logic [1:0]   opMode, opShift, opIdx;
  logic         doneValid, ovfFlag;
  logic [3:0]   accOvf;
  logic [191:0] accFlat;

  always #2 clk = ~clk;  // 250 MHz

  mac_unit u_mac_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opClear(opClear),
    .opA(opA), .opB(opB), .opMode(opMode), .opShift(opShift), .opSub(opSub),
    .opIdx(opIdx), .satMode(satMode), .roundEn(roundEn),
    .doneValid(doneValid), .ovfFlag(ovfFlag), .accOvf(accOvf), .accFlat(accFlat)
  );

  typedef struct {
    string        tag;
    logic [191:0] accs;
    logic         ovf;
    logic [3:0]   sticky;
  } expItem_t;

  expItem_t    expQ[$];
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;
  logic [47:0] mAcc [NA];
  logic        mOvf;
  logic [3:0]  mSticky;

  task automatic check(input bit ok, input string tag, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [191:0] packAccs();
    return {mAcc[3], mAcc[2], mAcc[1], mAcc[0]};
  endfunction

  // Product per R3..R7
  function automatic void modelProd(input logic [31:0] a, input logic [31:0] b,
                                    input logic [1:0] mode, input logic [1:0] sh,
                                    input logic sat, input logic rnd,
                                    output logic [63:0] p, output logic ov);
    longint      sp, q;
    logic [63:0] up;
    logic [23:0] r;
    sp = longint'($signed(a)) * longint'($signed(b));
    up = {32'b0, a} * {32'b0, b};
    ov = 1'b0;
    if (mode == 2'd1) begin
      if (up >= 64'h100_0000_0000) begin
        ov = 1'b1;
        p  = sat ? 64'h4_0000_0000_0000 : (up & 64'hFF_FFFF_FFFF);
      end else p = up;
    end else if (mode == 2'd2) begin
      r = sp[23:0];
      q = sp >>> 24;
      if (rnd && (r > 24'h800000 || (r == 24'h800000 && q[0]))) q = q + 1;
      p = q;
    end else begin
      if (sp < -(longint'(1) <<< 39) || sp >= (longint'(1) <<< 39)) begin
        ov = 1'b1;
        if (sat) p = (sp < 0) ? ~64'h4_0000_0000_0000 : 64'h4_0000_0000_0000;
        else     p = (sp <<< 24) >>> 24;
      end else p = sp;
    end
    if (sh == 2'd1)      p = p << 1;
    else if (sh == 2'd2) p = (mode == 2'd1) ? (p >> 1) : $unsigned($signed(p) >>> 1);
  endfunction

  task automatic doOp(input string tag, input logic [31:0] a, input logic [31:0] b,
                      input logic [1:0] mode, input logic [1:0] sh, input logic sub,
                      input logic [1:0] idx, input logic sat, input logic rnd);
    logic [63:0] p, ext, sum;
    logic        pov, so, v;
    logic [47:0] nxt;
    expItem_t    it;
    modelProd(a, b, mode, sh, sat, rnd, p, pov);
    ext = (mode == 2'd1) ? {16'b0, mAcc[idx]} : {{16{mAcc[idx][47]}}, mAcc[idx]};
    sum = sub ? ext - p : ext + p;
    nxt = sum[47:0];
    if (mode == 2'd1) begin
      so = (sum[63:48] != 16'd0);
      v  = so | pov;
      if (v && sat) nxt = (sum > 64'h20_0000_0000_0000) ? 48'd0 : 48'hFFFF_FFFF_FFFF;
    end else begin
      so = ($signed(sum) < -(longint'(1) <<< 47)) || ($signed(sum) >= (longint'(1) <<< 47));
      v  = so | pov;
      if (v && sat) begin
        if (mode == 2'd2) nxt = sum[63] ? 48'h8000_0000_0000 : 48'h7FFF_FFFF_FFFF;
        else              nxt = sum[63] ? 48'hFFFF_8000_0000 : 48'h0000_7FFF_FFFF;
      end
    end
    mAcc[idx] = nxt;
    mOvf = v;
    if (v) mSticky[idx] = 1'b1;
    it.tag = tag; it.accs = packAccs(); it.ovf = mOvf; it.sticky = mSticky;
    expQ.push_back(it);
    opValid = 1'b1; opClear = 1'b0; opA = a; opB = b; opMode = mode; opShift = sh;
    opSub = sub; opIdx = idx; satMode = sat; roundEn = rnd;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic doClear(input string tag, input logic [1:0] idx);
    expItem_t it;
    mAcc[idx] = '0;
    mSticky[idx] = 1'b0;
    it.tag = tag; it.accs = packAccs(); it.ovf = mOvf; it.sticky = mSticky;
    expQ.push_back(it);
    opValid = 1'b1; opClear = 1'b1; opIdx = idx;
    @(negedge clk);
    opValid = 1'b0; opClear = 1'b0;
  endtask

  // Monitor: pop and compare each retired operation
  always @(negedge clk) begin
    if (rstN === 1'b1 && doneValid === 1'b1 && !finished) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected doneValid", 192'(doneValid), 192'd0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(accFlat === it.accs && ovfFlag === it.ovf && accOvf === it.sticky,
              it.tag, {accFlat[186:0], ovfFlag, accOvf},
              {it.accs[186:0], it.ovf, it.sticky});
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NA; i++) mAcc[i] = '0;
    mOvf = 1'b0; mSticky = '0;
    rstN = 1'b0; opValid = 1'b0; opClear = 1'b0; opA = '0; opB = '0;
    opMode = '0; opShift = '0; opSub = 1'b0; opIdx = '0; satMode = 1'b0; roundEn = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    check(accFlat == '0 && accOvf == '0 && !ovfFlag && !doneValid, "R1 reset state",
          {accFlat[186:0], ovfFlag, accOvf}, 192'd0);

    // R2 latency: one op, pulse two edges later, one cycle wide
    doOp("R2/R3 signed 3*-5", 32'd3, -32'sd5, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0);
    check(doneValid === 1'b0, "R2 no result after one edge", 192'(doneValid), 192'd0);
    @(negedge clk);
    check(doneValid === 1'b1, "R2 result after two edges", 192'(doneValid), 192'd1);
    @(negedge clk);
    check(doneValid === 1'b0, "R2 single-cycle pulse", 192'(doneValid), 192'd0);

    doOp("R8 subtract 7*6", 32'd7, 32'd6, 2'd0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0);
    doOp("R3 code 3 signed", 32'd2, 32'hFFFF_FFFE, 2'd3, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0);
    doOp("R3 trunc ovf zero", 32'h4000_0000, 32'h4000_0000, 2'd0, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0);
    doOp("R3 trunc ovf low", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'd0, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0);
    doOp("R4 forced pos", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'd0, 2'd0, 1'b0, 2'd2, 1'b1, 1'b0);
    doOp("R4 forced neg", 32'h7FFF_FFFF, 32'h8000_0000, 2'd0, 2'd0, 1'b0, 2'd3, 1'b1, 1'b0);
    doOp("R13 sticky holds", 32'd1, 32'd1, 2'd0, 2'd0, 1'b0, 2'd2, 1'b1, 1'b0);
    doOp("R4 forced with left shift", 32'h8000_0000, 32'h7FFF_FFFF, 2'd0, 2'd1, 1'b1, 2'd2, 1'b1, 1'b0);
    doClear("R12 clear acc1", 2'd1);
    doClear("R12 clear acc2", 2'd2);
    doClear("R12 clear acc3", 2'd3);
    doOp("R5 unsigned trunc", 32'hFFFF_FFFF, 32'h200, 2'd1, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0);
    doOp("R5 unsigned below limit", 32'hFFFF_FFFF, 32'h100, 2'd1, 2'd0, 1'b0, 2'd1, 1'b1, 1'b0);
    doOp("R11 unsigned clamp max", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd1, 2'd0, 1'b0, 2'd2, 1'b1, 1'b0);
    doOp("R11 clamp max again", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd1, 2'd0, 1'b0, 2'd2, 1'b1, 1'b0);
    doOp("R11 unsigned load 5", 32'd5, 32'd1, 2'd1, 2'd0, 1'b0, 2'd3, 1'b1, 1'b0);
    doOp("R11 underflow to zero", 32'd10, 32'd1, 2'd1, 2'd0, 1'b1, 2'd3, 1'b1, 1'b0);
    doClear("R12 clear acc3 again", 2'd3);
    doOp("R11 underflow wraps", 32'd1, 32'd1, 2'd1, 2'd0, 1'b1, 2'd3, 1'b0, 1'b0);
    doClear("R12 clear acc0", 2'd0);
    doOp("R6 half even stays", 32'h0080_0000, 32'd1, 2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1);
    doOp("R6 half odd rounds", 32'h0080_0000, 32'd3, 2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1);
    doOp("R6 above half up", 32'h00C0_0000, 32'd1, 2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1);
    doOp("R6 no rounding", 32'h00C0_0000, 32'd1, 2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0);
    doOp("R6 negative half even", 32'hFE80_0000, 32'd1, 2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1);
    doOp("R6 negative truncate", 32'hFF40_0000, 32'd1, 2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0);
    doClear("R12 clear acc1 again", 2'd1);
    doOp("R7 signed right", -32'sd3, 32'd4, 2'd0, 2'd2, 1'b0, 2'd1, 1'b0, 1'b0);
    doOp("R7 signed left", -32'sd3, 32'd4, 2'd0, 2'd1, 1'b0, 2'd1, 1'b0, 1'b0);
    doOp("R7 unsigned right", 32'hFFFF_FFFF, 32'h80, 2'd1, 2'd2, 1'b0, 2'd1, 1'b0, 1'b0);
    doOp("R7 code 3 no shift", 32'd9, 32'd9, 2'd0, 2'd3, 1'b0, 2'd1, 1'b0, 1'b0);

    // R9/R10: signed integer wrap across the 48-bit boundary, saturate off
    doClear("R12 clear acc2 again", 2'd2);
    for (int i = 0; i < 140; i++)
      doOp("R9/R10 signed wrap", 32'h0007_FFFF, 32'h0010_0000, 2'd0, 2'd1, 1'b0, 2'd2, 1'b0, 1'b0);
    // R10: fractional clamp up, then down
    doClear("R12 clear acc3 frac", 2'd3);
    for (int i = 0; i < 560; i++)
      doOp("R10 frac clamp max", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'd2, 2'd0, 1'b0, 2'd3, 1'b1, 1'b1);
    for (int i = 0; i < 1100; i++)
      doOp("R10 frac clamp min", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'd2, 2'd0, 1'b1, 2'd3, 1'b1, 1'b0);
    doOp("R13 other accs intact", 32'd1, 32'd2, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R2 all operations retired", 192'(expQ.size()), 192'd0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule